// File: doc/BRIEF.md
# Dual-Pair Lockstep Result Checker

This block sits behind four identical processing units that together form one logical processor. The units are grouped as pair A and pair B. All four run the same work in lockstep, so in any cycle the two members of a pair should hand in the same result word. The checker compares the two members of each pair in that cycle. It forwards one result to a single registered output and keeps a health flag for each pair.

When the two members of a pair disagree, that pair loses its health flag. If the other pair is still healthy, the output switches to it within the same cycle, so the output gains no extra latency. The standby pair has been running in lockstep all along, so there is no voting and no failover pause. A maintenance pulse puts a repaired pair back in service. If both pairs are lost, the block raises a fatal error and stops producing valid output until reset. The block does not carry out state transfer into a replaced pair. It also checks the two pairs against each other, but only as an alert.

Top module: `dual_pair_lockstep_checker`

## Requirements
- R1: After a synchronous reset, both pair health flags read 1, out_valid, cross_alert and fatal_err read 0, and out_src reads 0.
- R2: If both members of a pair assert valid in a cycle and their data differ, that pair's health flag reads 0 from the next clock edge.
- R3: A pair is compared only in cycles where both of its members assert valid. A cycle where only one member is valid causes no fault, whatever the data.
- R4: A cleared health flag stays cleared until a reinstate pulse for that pair is honoured.
- R5: While pair A is healthy, the output comes from pair A (out_src = 0). One cycle after the inputs, out_valid is 1 exactly when both A members were valid and equal, and out_data is then A's result.
- R6: In the cycle where pair A faults while pair B stays healthy, the output of the next edge already carries pair B's result from that same cycle, with out_src = 1 (1 means pair B).
- R7: A reinstate pulse for a faulty pair is honoured only if the other pair's health flag is 1 and the other pair does not mismatch in that cycle, and only if the reinstated pair itself does not mismatch in that cycle. Otherwise the pulse has no effect. Once A is reinstated, the selection returns to A.
- R8: If both pairs stay healthy, both pairs agree internally, and the two pairs' results differ, cross_alert is 1 for the following cycle. The selection stays on pair A.
- R9: Once both health flags are 0, whether they were lost in the same cycle or one after the other, fatal_err reads 1 and out_valid reads 0 until reset. Reinstate pulses do not clear it.
- R10: out_data reads 0 in every cycle in which out_valid reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a0_valid | input | 1 | Pair A member 0 result valid |
| a0_data | input | DATA_W | Pair A member 0 result |
| a1_valid | input | 1 | Pair A member 1 result valid |
| a1_data | input | DATA_W | Pair A member 1 result |
| b0_valid | input | 1 | Pair B member 0 result valid |
| b0_data | input | DATA_W | Pair B member 0 result |
| b1_valid | input | 1 | Pair B member 1 result valid |
| b1_data | input | DATA_W | Pair B member 1 result |
| reinstate_a | input | 1 | Maintenance pulse: return pair A to service |
| reinstate_b | input | 1 | Maintenance pulse: return pair B to service |
| out_valid | output | 1 | Forwarded result valid |
| out_data | output | DATA_W | Forwarded result |
| out_src | output | 1 | Pair that supplied the result (0 = A, 1 = B) |
| pair_a_ok | output | 1 | Pair A health flag |
| pair_b_ok | output | 1 | Pair B health flag |
| cross_alert | output | 1 | Healthy pairs disagreed with each other |
| fatal_err | output | 1 | Both pairs lost |

## Verification
The bench builds the block with DATA_W = 4. At that width, every pair of values for the two members of one pair can be swept, for pair A and for pair B, with the other pair held healthy and reinstatement requested each cycle. This covers every agree and mismatch combination, every failover and every return to service. A long pseudo-random run then mixes partial valids, rare mismatches, reinstate pulses in both healthy and faulty states, and the double-fault path. Each output is compared against values the bench derives from the requirements.

// File: rtl/lockstep_pkg.sv
package lockstep_pkg;

  typedef enum logic {
    SRC_PAIR_A = 1'b0,
    SRC_PAIR_B = 1'b1
  } src_sel_e;

  // Result of checking one pair in one cycle
  typedef struct packed {
    logic agree;     // both members valid and equal
    logic disagree;  // both members valid and different
  } pair_cmp_t;

endpackage

// File: rtl/pair_compare.sv
module pair_compare
  import lockstep_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              unit0_valid_i,
  input  logic [DATA_W-1:0] unit0_data_i,
  input  logic              unit1_valid_i,
  input  logic [DATA_W-1:0] unit1_data_i,
  output pair_cmp_t         cmp_o
);

  logic both_valid;
  logic same;

  always_comb begin
    both_valid      = unit0_valid_i && unit1_valid_i;
    same            = (unit0_data_i == unit1_data_i);
    cmp_o.agree     = both_valid && same;
    cmp_o.disagree  = both_valid && !same;
  end

endmodule

// File: rtl/pair_health.sv
module pair_health (
  input  logic clk,
  input  logic rst,
  input  logic disagree_i,
  input  logic reinstate_i,
  input  logic peer_ok_i,
  input  logic peer_disagree_i,
  output logic ok_q,
  output logic ok_next
);

  // Sticky fault; repair only accepted while the peer carries the load
  always_comb begin
    if (ok_q) begin
      ok_next = !disagree_i;
    end else begin
      ok_next = reinstate_i && peer_ok_i && !peer_disagree_i && !disagree_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ok_q <= 1'b1;
    end else begin
      ok_q <= ok_next;
    end
  end

  // R4: a faulty pair with no reinstate pulse stays faulty
  a_r4_fault_held: assert property (@(posedge clk) disable iff (rst)
    (!ok_q && !reinstate_i) |=> !ok_q);

  // R7: reinstate is refused while the peer is down
  a_r7_refused_without_peer: assert property (@(posedge clk) disable iff (rst)
    (!ok_q && !peer_ok_i) |=> !ok_q);

endmodule

// File: rtl/result_select.sv
module result_select
  import lockstep_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        ok_next_i,
  input  logic [1:0]        agree_i,
  input  logic [DATA_W-1:0] data_a_i,
  input  logic [DATA_W-1:0] data_b_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_src_o,
  output logic              cross_alert_o,
  output logic              fatal_o
);

  src_sel_e          src_n, src_q;
  logic              fatal_n, fatal_q;
  logic              valid_n, valid_q;
  logic              cross_n, cross_q;
  logic [DATA_W-1:0] data_n, data_q;

  always_comb begin
    fatal_n = fatal_q || (!ok_next_i[0] && !ok_next_i[1]);
    src_n   = (!ok_next_i[0] && ok_next_i[1]) ? SRC_PAIR_B : SRC_PAIR_A;
    if (src_n == SRC_PAIR_B) begin
      valid_n = agree_i[1];
      data_n  = data_b_i;
    end else begin
      valid_n = agree_i[0];
      data_n  = data_a_i;
    end
    if (fatal_n) begin
      valid_n = 1'b0;
    end
    if (!valid_n) begin
      data_n = '0;
    end
    cross_n = ok_next_i[0] && ok_next_i[1] && agree_i[0] && agree_i[1]
              && (data_a_i != data_b_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q   <= SRC_PAIR_A;
      fatal_q <= 1'b0;
      valid_q <= 1'b0;
      data_q  <= '0;
      cross_q <= 1'b0;
    end else begin
      src_q   <= src_n;
      fatal_q <= fatal_n;
      valid_q <= valid_n;
      data_q  <= data_n;
      cross_q <= cross_n;
    end
  end

  assign out_valid_o   = valid_q;
  assign out_data_o    = data_q;
  assign out_src_o     = src_q;
  assign cross_alert_o = cross_q;
  assign fatal_o       = fatal_q;

  // R9: fatal state is held until reset
  a_r9_fatal_sticky: assert property (@(posedge clk) disable iff (rst)
    fatal_q |=> fatal_q);

endmodule

// File: rtl/dual_pair_lockstep_checker.sv
module dual_pair_lockstep_checker
  import lockstep_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a0_valid,
  input  logic [DATA_W-1:0] a0_data,
  input  logic              a1_valid,
  input  logic [DATA_W-1:0] a1_data,
  input  logic              b0_valid,
  input  logic [DATA_W-1:0] b0_data,
  input  logic              b1_valid,
  input  logic [DATA_W-1:0] b1_data,
  input  logic              reinstate_a,
  input  logic              reinstate_b,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_src,
  output logic              pair_a_ok,
  output logic              pair_b_ok,
  output logic              cross_alert,
  output logic              fatal_err
);

  localparam int NPAIR = 2;

  logic [NPAIR-1:0]  m0_valid, m1_valid, reinst, ok_q, ok_n, agree;
  logic [DATA_W-1:0] m0_data [NPAIR];
  logic [DATA_W-1:0] m1_data [NPAIR];
  pair_cmp_t         cmp     [NPAIR];

  assign m0_valid   = {b0_valid, a0_valid};
  assign m1_valid   = {b1_valid, a1_valid};
  assign reinst     = {reinstate_b, reinstate_a};
  assign m0_data[0] = a0_data;
  assign m0_data[1] = b0_data;
  assign m1_data[0] = a1_data;
  assign m1_data[1] = b1_data;

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    pair_compare #(.DATA_W(DATA_W)) u_cmp (
      .unit0_valid_i (m0_valid[p]),
      .unit0_data_i  (m0_data[p]),
      .unit1_valid_i (m1_valid[p]),
      .unit1_data_i  (m1_data[p]),
      .cmp_o         (cmp[p])
    );

    pair_health u_health (
      .clk             (clk),
      .rst             (rst),
      .disagree_i      (cmp[p].disagree),
      .reinstate_i     (reinst[p]),
      .peer_ok_i       (ok_q[NPAIR-1-p]),
      .peer_disagree_i (cmp[NPAIR-1-p].disagree),
      .ok_q            (ok_q[p]),
      .ok_next         (ok_n[p])
    );

    assign agree[p] = cmp[p].agree;
  end

  result_select #(.DATA_W(DATA_W)) u_sel (
    .clk           (clk),
    .rst           (rst),
    .ok_next_i     (ok_n),
    .agree_i       (agree),
    .data_a_i      (m0_data[0]),
    .data_b_i      (m0_data[1]),
    .out_valid_o   (out_valid),
    .out_data_o    (out_data),
    .out_src_o     (out_src),
    .cross_alert_o (cross_alert),
    .fatal_o       (fatal_err)
  );

  assign pair_a_ok = ok_q[0];
  assign pair_b_ok = ok_q[1];

  // R2: a valid mismatch inside pair A removes it from service
  a_r2_mismatch_clears_a: assert property (@(posedge clk) disable iff (rst)
    (a0_valid && a1_valid && (a0_data != a1_data)) |=> !pair_a_ok);

  // R3: without both valids a healthy pair stays healthy
  a_r3_partial_valid_no_fault: assert property (@(posedge clk) disable iff (rst)
    (pair_b_ok && !(b0_valid && b1_valid)) |=> pair_b_ok);

  // R9: no valid output while fatal
  a_r9_fatal_blocks_valid: assert property (@(posedge clk) disable iff (rst)
    fatal_err |-> !out_valid);

  // R10: idle output is zero
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (out_data == '0));

  // R8: an inter-pair alert never moves the selection off pair A
  a_r8_alert_keeps_a: assert property (@(posedge clk) disable iff (rst)
    cross_alert |-> (out_src == 1'b0));

  // R6: a mismatch in A with B healthy and agreeing switches to B at once
  a_r6_instant_failover: assert property (@(posedge clk) disable iff (rst)
    (a0_valid && a1_valid && (a0_data != a1_data) && pair_b_ok
     && b0_valid && b1_valid && (b0_data == b1_data))
    |=> (out_valid && out_src));

endmodule

// File: tb/dual_pair_lockstep_checker_test.sv
module dual_pair_lockstep_checker_test;

  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         a0v, a1v, b0v, b1v, ra, rb;
  logic [W-1:0] a0d, a1d, b0d, b1d;
  logic         o_valid, o_src, o_aok, o_bok, o_cross, o_fatal;
  logic [W-1:0] o_data;

  int total = 0;
  int bad   = 0;
  logic done = 1'b0;

  logic m_oka, m_okb, m_fat;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  dual_pair_lockstep_checker #(.DATA_W(W)) uut (
    .clk(clk), .rst(rst),
    .a0_valid(a0v), .a0_data(a0d), .a1_valid(a1v), .a1_data(a1d),
    .b0_valid(b0v), .b0_data(b0d), .b1_valid(b1v), .b1_data(b1d),
    .reinstate_a(ra), .reinstate_b(rb),
    .out_valid(o_valid), .out_data(o_data), .out_src(o_src),
    .pair_a_ok(o_aok), .pair_b_ok(o_bok),
    .cross_alert(o_cross), .fatal_err(o_fatal)
  );

  task automatic chk(input string tag, input string fld,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: got %0h expected %0h", tag, fld, act, exp);
    end
  endtask

  task automatic drive(input logic av0, input logic [W-1:0] ad0,
                       input logic av1, input logic [W-1:0] ad1,
                       input logic bv0, input logic [W-1:0] bd0,
                       input logic bv1, input logic [W-1:0] bd1,
                       input logic pa, input logic pb);
    a0v = av0; a0d = ad0; a1v = av1; a1d = ad1;
    b0v = bv0; b0d = bd0; b1v = bv1; b1d = bd1;
    ra = pa; rb = pb;
  endtask

  // Expected values follow the requirement list; one-cycle latency
  task automatic step(input string tag);
    logic ag_a, ag_b, ds_a, ds_b, n_a, n_b, n_f, sel_b, e_v, e_x;
    logic [W-1:0] e_d;
    ag_a = a0v && a1v && (a0d == a1d);
    ds_a = a0v && a1v && (a0d != a1d);
    ag_b = b0v && b1v && (b0d == b1d);
    ds_b = b0v && b1v && (b0d != b1d);
    n_a  = m_oka ? !ds_a : (ra && m_okb && !ds_b && !ds_a);
    n_b  = m_okb ? !ds_b : (rb && m_oka && !ds_a && !ds_b);
    n_f  = m_fat || (!n_a && !n_b);
    sel_b = !n_a && n_b;
    e_v  = !n_f && (sel_b ? ag_b : ag_a);
    e_d  = e_v ? (sel_b ? b0d : a0d) : '0;
    e_x  = n_a && n_b && ag_a && ag_b && (a0d != b0d);
    @(posedge clk);
    @(negedge clk);
    m_oka = n_a; m_okb = n_b; m_fat = n_f;
    chk(tag, "out_valid", {31'd0, o_valid}, {31'd0, e_v});
    chk(tag, "out_data", {28'd0, o_data}, {28'd0, e_d});
    chk(tag, "out_src", {31'd0, o_src}, {31'd0, sel_b});
    chk(tag, "pair_a_ok", {31'd0, o_aok}, {31'd0, n_a});
    chk(tag, "pair_b_ok", {31'd0, o_bok}, {31'd0, n_b});
    chk(tag, "cross_alert", {31'd0, o_cross}, {31'd0, e_x});
    chk(tag, "fatal_err", {31'd0, o_fatal}, {31'd0, n_f});
  endtask

  task automatic do_reset();
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    m_oka = 1'b1; m_okb = 1'b1; m_fat = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: reset state
    chk("R1", "out_valid", {31'd0, o_valid}, 0);
    chk("R1", "pair_a_ok", {31'd0, o_aok}, 1);
    chk("R1", "pair_b_ok", {31'd0, o_bok}, 1);
    chk("R1", "fatal_err", {31'd0, o_fatal}, 0);
    chk("R1", "cross_alert", {31'd0, o_cross}, 0);
    chk("R1", "out_src", {31'd0, o_src}, 0);

    drive(1, 5, 1, 5, 1, 5, 1, 5, 0, 0); step("R5");
    drive(1, 3, 0, 9, 1, 7, 1, 7, 0, 0); step("R3");
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0); step("R10");
    drive(1, 2, 1, 2, 1, 6, 1, 6, 0, 0); step("R8");
    drive(1, 1, 1, 4, 1, 12, 1, 12, 0, 0); step("R6");
    drive(1, 3, 1, 3, 1, 3, 1, 3, 0, 0); step("R4");
    drive(1, 3, 1, 3, 1, 3, 1, 3, 0, 0); step("R4");
    drive(1, 8, 1, 8, 1, 9, 1, 9, 1, 0); step("R7");
    drive(1, 8, 1, 8, 1, 8, 1, 8, 0, 0); step("R5");

    do_reset();
    drive(1, 4, 1, 4, 1, 2, 1, 3, 0, 0); step("R2");
    drive(1, 6, 1, 6, 1, 6, 1, 6, 0, 1); step("R7");
    drive(1, 1, 1, 2, 1, 6, 1, 6, 0, 0); step("R6");
    drive(1, 5, 1, 5, 1, 3, 1, 4, 1, 0); step("R7");
    drive(1, 5, 1, 5, 1, 5, 1, 5, 1, 1); step("R9");
    drive(1, 7, 1, 7, 1, 7, 1, 7, 0, 0); step("R9");

    do_reset();
    drive(1, 1, 1, 0, 1, 2, 1, 0, 0, 0); step("R9");
    drive(1, 2, 1, 2, 1, 2, 1, 2, 1, 1); step("R9");

    // R2/R6/R7 sweep over every value pair in pair A, then pair B
    do_reset();
    for (int i = 0; i < 256; i++) begin
      drive(1, i[7:4], 1, i[3:0], 1, i[7:4], 1, i[7:4], 1, 0);
      step("R2");
    end
    do_reset();
    for (int i = 0; i < 256; i++) begin
      drive(1, i[7:4], 1, i[7:4], 1, i[7:4], 1, i[3:0], 0, 1);
      step("R7");
    end

    // Mixed pseudo-random run covering R3, R4, R5, R8, R9
    do_reset();
    for (int n = 0; n < 4000; n++) begin
      logic [W-1:0] base, alt;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      base = lfsr[3:0];
      alt  = lfsr[7:4];
      drive(lfsr[8] | lfsr[9], base,
            lfsr[8] | lfsr[10], (lfsr[15:12] == 4'd0) ? ~base : base,
            lfsr[9] | lfsr[11], lfsr[14] ? alt : base,
            lfsr[10] | lfsr[11], (lfsr[15:12] == 4'd1) ? ~(lfsr[14] ? alt : base)
                                                       : (lfsr[14] ? alt : base),
            lfsr[13] & lfsr[2], lfsr[13] & lfsr[1]);
      step("R5");
      if (m_fat && lfsr[5:4] == 2'b00) do_reset();
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule